// File: doc/BRIEF.md
# Outstanding Miss Tracking Table

This block keeps a small table of cache misses that have gone to the next memory level and not yet come back. Each entry records the request command, the virtual address, the physical line address, the victim way the cache chose for the refill, and a flag that says whether a buffered write is waiting on the line. Only the tracking and matching is done here. Victim choice and the protocol toward the next level belong to other blocks.

The cache presents an allocation request and gets an answer in the same cycle. A new line takes the lowest free slot. A request that can share an entry already pending for the same line joins that entry, and the cache stalls on it. A request that needs stronger ownership than the pending entry is refused as a conflict. A request that finds no free slot is refused as full. In both refusal cases the CPU retries later.

A release names an entry index. The block returns what the entry holds and frees the entry at the next edge. A release is used when a fill completes and also, with no delay, when the next level answers retry or bus error.

Top module: `miss_table`

## Requirements
- R1: While reset is held, every entry becomes free. After reset, a release of any index reports done_live=0, and the first allocation succeeds with index 0.
- R2: An allocation whose line matches no live entry, when a slot is free, returns code 0 (success) with the lowest free index. That entry then holds the request's command, virtual address, line, way and write-buffer flag.
- R3: An allocation whose line matches no live entry, when all entries are live, returns code 3 (full) and changes no entry.
- R4: An allocation whose line matches a live entry returns code 1 (merge) with that entry's index and creates no entry, if the new command does not need exclusive ownership (cmd bit 0 = 0) or the stored command already has it (stored bit 0 = 1).
- R5: An allocation whose line matches a live entry holding a shared command (bit 0 = 0), when the new command has bit 0 = 1, returns code 2 (conflict) with index 0 and changes no entry.
- R6: A release reports the entry's stored command, way and write-buffer flag, with done_live=1 if the entry was live and 0 if it was free, and the entry is free from the next cycle.
- R7: An entry released in the same cycle as an allocation is left out of the line match and counts as a free slot for that allocation.
- R8: A line match takes priority over fullness: when all entries are live, a matching request still gets merge or conflict, not full.
- R9: A release also reports the virtual address stored at allocation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request present |
| alloc_cmd | input | 2 | Request command; bit 0 set means exclusive ownership needed |
| alloc_vaddr | input | VA_W | Virtual address of the access |
| alloc_line | input | LA_W | Physical line address |
| alloc_way | input | WAY_W | Victim way chosen by the cache |
| alloc_wbuf | input | 1 | A buffered write waits on this line |
| alloc_res | output | 2 | 0 success, 1 merge, 2 conflict, 3 full |
| alloc_index | output | IDX_W | Allocated or joined entry; 0 when refused |
| done_valid | input | 1 | Release request (fill, retry or bus error) |
| done_index | input | IDX_W | Entry to release |
| done_live | output | 1 | Released entry was occupied |
| done_cmd | output | 2 | Stored command of the released entry |
| done_vaddr | output | VA_W | Stored virtual address |
| done_way | output | WAY_W | Stored victim way |
| done_wbuf | output | 1 | Stored write-buffer flag |

## Verification
The bench checks the ownership rule in both directions. A shared request joining an exclusive entry must merge, and an exclusive request hitting a shared entry must be refused. A design that compared the wrong bit would either merge an upgrade the line cannot serve or block a harmless read. With the table full, the bench sends matching requests, and a design that checked fullness first would answer full where merge or conflict is right. The bench also releases an entry and allocates in the same cycle, once for a line that matches the released entry and once for a new line. A design that still matched the dying entry would merge onto a slot that is being freed, or would report full. Finally, a slot refilled after an earlier release must be the lowest free one, and it must return its own way and virtual address.

// File: rtl/miss_table_pkg.sv
package miss_table_pkg;
  typedef enum logic [1:0] {
    RES_OK       = 2'd0,
    RES_MERGE    = 2'd1,
    RES_CONFLICT = 2'd2,
    RES_FULL     = 2'd3
  } alloc_res_e;

  // bit 0 of a command means the requester needs exclusive ownership
  function automatic logic needs_excl(input logic [1:0] cmd);
    return cmd[0];
  endfunction

  // a new command may ride on a pending one if it asks no more ownership
  function automatic logic can_join(input logic [1:0] new_cmd, input logic [1:0] old_cmd);
    return !needs_excl(new_cmd) || needs_excl(old_cmd);
  endfunction
endpackage

// File: rtl/mht_slot.sv
module mht_slot #(
  parameter int VA_W  = 32,
  parameter int LA_W  = 26,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [1:0]       cmd_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [LA_W-1:0]  line_i,
  input  logic [WAY_W-1:0] way_i,
  input  logic             wbuf_i,
  output logic             live_o,
  output logic [1:0]       cmd_o,
  output logic [VA_W-1:0]  vaddr_o,
  output logic [LA_W-1:0]  line_o,
  output logic [WAY_W-1:0] way_o,
  output logic             wbuf_o
);
  // set wins over clear: a slot released and refilled in one cycle stays live
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_o <= 1'b0;
    end else if (set_i) begin
      live_o <= 1'b1;
    end else if (clr_i) begin
      live_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (set_i) begin
      cmd_o   <= cmd_i;
      vaddr_o <= vaddr_i;
      line_o  <= line_i;
      way_o   <= way_i;
      wbuf_o  <= wbuf_i;
    end
  end
endmodule

// File: rtl/mht_match.sv
module mht_match #(
  parameter int N    = 4,
  parameter int LA_W = 26
) (
  input  logic [N-1:0]           live_i,
  input  logic [N-1:0][LA_W-1:0] line_i,
  input  logic [LA_W-1:0]        req_line_i,
  output logic [N-1:0]           hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = live_i[g] && (line_i[g] == req_line_i);
  end
endmodule

// File: rtl/mht_pick.sv
module mht_pick #(
  parameter int N = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest set bit wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/miss_table.sv
module miss_table
  import miss_table_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int VA_W    = 32,
  parameter int LA_W    = 26,
  parameter int WAY_W   = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  input  logic [1:0]       alloc_cmd,
  input  logic [VA_W-1:0]  alloc_vaddr,
  input  logic [LA_W-1:0]  alloc_line,
  input  logic [WAY_W-1:0] alloc_way,
  input  logic             alloc_wbuf,
  output logic [1:0]       alloc_res,
  output logic [IDX_W-1:0] alloc_index,
  input  logic             done_valid,
  input  logic [IDX_W-1:0] done_index,
  output logic             done_live,
  output logic [1:0]       done_cmd,
  output logic [VA_W-1:0]  done_vaddr,
  output logic [WAY_W-1:0] done_way,
  output logic             done_wbuf
);
  logic [ENTRIES-1:0]             live;
  logic [ENTRIES-1:0][1:0]        cmd_a;
  logic [ENTRIES-1:0][VA_W-1:0]   vaddr_a;
  logic [ENTRIES-1:0][LA_W-1:0]   line_a;
  logic [ENTRIES-1:0][WAY_W-1:0]  way_a;
  logic [ENTRIES-1:0]             wbuf_a;

  // named internal events
  logic [ENTRIES-1:0] rel_vec;   // entry being released this cycle
  logic [ENTRIES-1:0] eff_live;  // entries that count for matching/allocation
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] set_vec;
  logic               hit_any, free_any;
  logic [IDX_W-1:0]   hit_idx, free_idx;
  alloc_res_e         res;

  assign rel_vec  = done_valid ? (ENTRIES'(1) << done_index) : '0;
  assign eff_live = live & ~rel_vec;

  mht_match #(.N(ENTRIES), .LA_W(LA_W)) u_match (
    .live_i(eff_live), .line_i(line_a), .req_line_i(alloc_line), .hit_o(hit_vec)
  );

  mht_pick #(.N(ENTRIES)) u_pick_hit (
    .vec_i(hit_vec), .found_o(hit_any), .idx_o(hit_idx)
  );

  mht_pick #(.N(ENTRIES)) u_pick_free (
    .vec_i(~eff_live), .found_o(free_any), .idx_o(free_idx)
  );

  always_comb begin
    res         = RES_FULL;
    alloc_index = '0;
    if (hit_any) begin
      if (can_join(alloc_cmd, cmd_a[hit_idx])) begin
        res         = RES_MERGE;
        alloc_index = hit_idx;
      end else begin
        res = RES_CONFLICT;
      end
    end else if (free_any) begin
      res         = RES_OK;
      alloc_index = free_idx;
    end
  end
  assign alloc_res = res;

  assign set_vec = (alloc_valid && res == RES_OK) ? (ENTRIES'(1) << free_idx) : '0;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    mht_slot #(.VA_W(VA_W), .LA_W(LA_W), .WAY_W(WAY_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_vec[g]), .clr_i(rel_vec[g]),
      .cmd_i(alloc_cmd), .vaddr_i(alloc_vaddr), .line_i(alloc_line),
      .way_i(alloc_way), .wbuf_i(alloc_wbuf),
      .live_o(live[g]), .cmd_o(cmd_a[g]), .vaddr_o(vaddr_a[g]),
      .line_o(line_a[g]), .way_o(way_a[g]), .wbuf_o(wbuf_a[g])
    );
  end

  assign done_live  = live[done_index];
  assign done_cmd   = cmd_a[done_index];
  assign done_vaddr = vaddr_a[done_index];
  assign done_way   = way_a[done_index];
  assign done_wbuf  = wbuf_a[done_index];

  // R1: reset clears every slot
  p_reset_empty_r1: assert property (@(posedge clk) !rst_n |=> (live == '0));

  // R2: a successful allocation leaves the chosen slot live with the line
  p_alloc_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && res == RES_OK) |=>
      (live[$past(alloc_index)] && line_a[$past(alloc_index)] == $past(alloc_line)));

  // R3: full only when no slot is free
  p_full_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && res == RES_FULL) |-> (&eff_live));

  // R4: merge points at a live slot of the same line
  p_merge_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && res == RES_MERGE) |->
      (eff_live[alloc_index] && line_a[alloc_index] == alloc_line));

  // R5: a refused request consumes no slot
  p_refuse_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && (res == RES_CONFLICT || res == RES_FULL)) |=>
      (live == $past(live & ~rel_vec)));

  // R6: a release frees its slot unless it was refilled in the same cycle
  p_release_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !(alloc_valid && res == RES_OK && alloc_index == done_index)) |=>
      !live[$past(done_index)]);
endmodule

// File: tb/miss_table_test.sv
module miss_table_test;
  localparam int N = 4, VA_W = 32, LA_W = 26, WAY_W = 2, IDX_W = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             alloc_valid = 1'b0;
  logic [1:0]       alloc_cmd = '0;
  logic [VA_W-1:0]  alloc_vaddr = '0;
  logic [LA_W-1:0]  alloc_line = '0;
  logic [WAY_W-1:0] alloc_way = '0;
  logic             alloc_wbuf = 1'b0;
  logic [1:0]       alloc_res;
  logic [IDX_W-1:0] alloc_index;
  logic             done_valid = 1'b0;
  logic [IDX_W-1:0] done_index = '0;
  logic             done_live;
  logic [1:0]       done_cmd;
  logic [VA_W-1:0]  done_vaddr;
  logic [WAY_W-1:0] done_way;
  logic             done_wbuf;

  miss_table uut (.*);

  always #5 clk = ~clk;

  typedef struct {
    string           tag;
    bit              chk_a;
    logic [1:0]      res;
    logic [IDX_W-1:0] idx;
    bit              chk_d;
    logic            live;
    logic [1:0]      cmd;
    logic [VA_W-1:0] va;
    logic [WAY_W-1:0] way;
    logic            wbuf;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  bit driving_done = 0;

  // reference model
  bit               m_live [N];
  logic [1:0]       m_cmd  [N];
  logic [VA_W-1:0]  m_va   [N];
  logic [LA_W-1:0]  m_line [N];
  logic [WAY_W-1:0] m_way  [N];
  logic             m_wbuf [N];

  task automatic op(input bit da, input logic [1:0] c, input logic [VA_W-1:0] va,
                    input logic [LA_W-1:0] ln, input logic [WAY_W-1:0] w, input logic wb,
                    input bit dr, input int ri, input string tag);
    item_t it;
    bit eff [N];
    int hit, fr;
    @(negedge clk);
    alloc_valid = da; alloc_cmd = c; alloc_vaddr = va; alloc_line = ln;
    alloc_way = w; alloc_wbuf = wb; done_valid = dr; done_index = IDX_W'(ri);
    it.tag = tag; it.chk_a = da; it.chk_d = dr;
    it.live = 0; it.cmd = '0; it.va = '0; it.way = '0; it.wbuf = 0;
    if (dr) begin
      it.live = m_live[ri]; it.cmd = m_cmd[ri]; it.va = m_va[ri];
      it.way = m_way[ri]; it.wbuf = m_wbuf[ri];
    end
    hit = -1; fr = -1;
    for (int i = 0; i < N; i++) eff[i] = m_live[i] && !(dr && ri == i);
    for (int i = N - 1; i >= 0; i--) begin
      if (eff[i] && m_line[i] == ln) hit = i;
      if (!eff[i]) fr = i;
    end
    if (hit >= 0) begin
      if (!c[0] || m_cmd[hit][0]) begin it.res = 2'd1; it.idx = IDX_W'(hit); end
      else begin it.res = 2'd2; it.idx = '0; end
    end else if (fr >= 0) begin
      it.res = 2'd0; it.idx = IDX_W'(fr);
    end else begin
      it.res = 2'd3; it.idx = '0;
    end
    q.push_back(it);
    if (dr) m_live[ri] = 0;
    if (da && it.res == 2'd0) begin
      m_live[fr] = 1; m_cmd[fr] = c; m_va[fr] = va; m_line[fr] = ln;
      m_way[fr] = w; m_wbuf[fr] = wb;
    end
  endtask

  // monitor: compare before the next rising edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        it = q.pop_front();
        if (it.chk_a) begin
          total++;
          if (alloc_res !== it.res || alloc_index !== it.idx) begin
            bad++;
            $display("FAIL %s alloc: got res=%0d idx=%0d expected res=%0d idx=%0d",
                     it.tag, alloc_res, alloc_index, it.res, it.idx);
          end
        end
        if (it.chk_d) begin
          total++;
          if (done_live !== it.live || (it.live && (done_cmd !== it.cmd ||
              done_vaddr !== it.va || done_way !== it.way || done_wbuf !== it.wbuf))) begin
            bad++;
            $display("FAIL %s release: got live=%0b cmd=%0d va=%h way=%0d wb=%0b expected live=%0b cmd=%0d va=%h way=%0d wb=%0b",
                     it.tag, done_live, done_cmd, done_vaddr, done_way, done_wbuf,
                     it.live, it.cmd, it.va, it.way, it.wbuf);
          end
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_live[i] = 0; m_cmd[i] = '0; m_va[i] = '0; m_line[i] = '0; m_way[i] = '0; m_wbuf[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: empty after reset
    op(0, 0, 0, 0, 0, 0, 1, 2, "R1 release free slot");
    op(1, 2'd0, 32'h1000_0040, 26'h40, 2'd1, 0, 0, 0, "R1 first alloc");
    // R2: lowest free slots
    op(1, 2'd1, 32'h2000_0080, 26'h80, 2'd2, 1, 0, 0, "R2 second alloc");
    op(1, 2'd2, 32'h3000_00c0, 26'hc0, 2'd3, 0, 0, 0, "R2 third alloc");
    // R5: exclusive onto shared line
    op(1, 2'd1, 32'h1000_0044, 26'h40, 2'd0, 0, 0, 0, "R5 upgrade conflict");
    op(1, 2'd3, 32'h3000_00c8, 26'hc0, 2'd0, 0, 0, 0, "R5 ll-excl conflict");
    // R4: merges
    op(1, 2'd0, 32'h1000_0048, 26'h40, 2'd0, 0, 0, 0, "R4 shared onto shared");
    op(1, 2'd2, 32'h2000_0084, 26'h80, 2'd0, 0, 0, 0, "R4 shared onto excl");
    op(1, 2'd1, 32'h2000_0088, 26'h80, 2'd0, 0, 0, 0, "R4 excl onto excl");
    // fill table, then R3 full
    op(1, 2'd1, 32'h4000_0100, 26'h100, 2'd0, 1, 0, 0, "R2 fourth alloc");
    op(1, 2'd0, 32'h5000_0140, 26'h140, 2'd1, 0, 0, 0, "R3 full");
    // R8: matches win over full
    op(1, 2'd0, 32'h4000_0104, 26'h100, 2'd2, 0, 0, 0, "R8 merge when full");
    op(1, 2'd1, 32'h3000_00c4, 26'hc0, 2'd2, 0, 0, 0, "R8 conflict when full");
    // R6/R9: release reports contents
    op(0, 0, 0, 0, 0, 0, 1, 1, "R6 R9 release slot1");
    op(1, 2'd0, 32'h5000_0140, 26'h140, 2'd1, 1, 0, 0, "R2 refill lowest free");
    // R7: release and allocate same line in one cycle
    op(1, 2'd1, 32'h1000_0050, 26'h40, 2'd3, 1, 1, 0, "R7 release+alloc same line");
    op(1, 2'd0, 32'h6000_0180, 26'h180, 2'd2, 0, 1, 3, "R7 release+alloc when full");
    op(0, 0, 0, 0, 0, 0, 1, 0, "R6 R9 release slot0");
    op(0, 0, 0, 0, 0, 0, 1, 0, "R6 release again");
    op(1, 2'd0, 32'h6000_0184, 26'h180, 2'd1, 0, 1, 3, "R7 released entry not matched");
    op(0, 0, 0, 0, 0, 0, 1, 2, "R6 R9 release slot2");
    op(0, 0, 0, 0, 0, 0, 0, 0, "idle");
    @(negedge clk);
    alloc_valid = 0; done_valid = 0;
    repeat (3) @(negedge clk);
    driving_done = 1;
  end

  initial begin
    fork
      wait (driving_done);
      begin
        repeat (5000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule